// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block receives a card-to-reader frame on the reader side of a contactless link. The link has no start marker, no stop marker and no length field, so the controlling logic must say how many bits it expects. A pulse on `start_i` marks the end of the reader's own frame. The block then waits a fixed number of timing ticks and cuts the hysteresis-filtered subcarrier input into back-to-back bit windows of equal length. It counts the level transitions inside each window. A window whose count falls strictly inside a tolerance band decodes as a 1. Any other count decodes as a 0.

The keystream word for the frame is prepared before reception begins and is captured at `start_i`. Each decoded 1 flips the matching bit of that preloaded word, so the result is the received bits XORed with the keystream. A card that sends only zeros cannot be told apart from an absent card. For that reason the block always runs every requested window. When the frame ends, the block pulses `done_o` and clears its shared tick timer, which lines up the next exchange.

Top module: `sc_edge_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `data_o`, `nbits_o` and `time_o` are all zero.
- R2: A `start_i` pulse sets `busy_o` on the next cycle, clears `time_o`, and clears `data_o` and `nbits_o` until the frame completes.
- R3: The first bit window opens `START_DLY` ticks after `start_i`. One tick is `TICK_DIV` clock cycles.
- R4: Bit windows are each `WIN_TICKS` ticks long and follow each other with no gap.
- R5: A window decodes as 1 when its transition count is greater than `CNT_LO` and less than `CNT_HI`. It decodes as 0 otherwise, including at exactly `CNT_LO` and exactly `CNT_HI`.
- R6: Decoded bits fill the word from the least significant end. Window k drives bit k of `data_o`.
- R7: A requested count above `MAX_BITS` is clamped to `MAX_BITS`. `nbits_o` reports the clamped count.
- R8: `data_o` equals the decoded bits XOR the keystream sampled at `start_i`. Bits at or above the bit count read 0. Changes on `ks_i` after `start_i` have no effect.
- R9: The per-window transition counter saturates at its all-ones value instead of wrapping. It restarts at every window boundary.
- R10: The block always spends the full requested number of windows, even when every window decodes as 0.
- R11: `done_o` is high for exactly one cycle. `data_o` and `nbits_o` then hold until the next `start_i`.
- R12: In the cycle where `done_o` is high, `time_o` is zero, and it counts up from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | End of reader frame; begins a reception |
| nbits_i | input | NB_IN_W | Requested number of bits |
| ks_i | input | MAX_BITS | Precomputed keystream word |
| sc_i | input | 1 | Hysteresis-filtered subcarrier level |
| busy_o | output | 1 | Reception in progress |
| done_o | output | 1 | One-cycle frame-complete pulse |
| data_o | output | MAX_BITS | Decrypted received word |
| nbits_o | output | $clog2(MAX_BITS+1) | Bit count actually received |
| time_o | output | TIME_W | Shared tick timer |

## Verification
The bench builds the block with a 2-cycle tick, a 10-tick lead-in, 12-tick windows, a band of 3 to 8 and a 4-bit transition counter. With these values a full 32-bit frame takes under 800 cycles. The 4-bit counter can be pushed past its maximum of 15 with 20 edges in one window, so a wrapping counter would yield a false 1. The short windows and narrow band also let every band edge, the clamp from 40 requested bits, and many random frames with random keystreams fit in a short run.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sc_rx_timebase.sv
module sc_rx_timebase #(
  parameter int TICK_DIV = 32,
  parameter int TIME_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic              tick_o,
  output logic [TIME_W-1:0] time_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0]     PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

  logic [PW-1:0]     pre_q;
  logic [TIME_W-1:0] time_q;

  assign tick_o = (pre_q == PRE_LAST);
  assign time_o = time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      time_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      time_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o && time_q != TIME_MAX) time_q <= time_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_rx_edge_cnt.sv
module sc_rx_edge_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             sc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             edge_seen;

  assign edge_seen = sc_i ^ sc_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      sc_q <= sc_i;
      if (clr_i)                             cnt_q <= '0;
      else if (edge_seen && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: a full counter stays full until the window restarts
  p_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  // R9: within a window the count never goes down (no wrap)
  p_nowrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
  import sc_rx_pkg::*;
#(
  parameter int START_DLY = 490,
  parameter int WIN_TICKS = 150,
  parameter int CNT_LO    = 20,
  parameter int CNT_HI    = 60,
  parameter int MAX_BITS  = 32,
  parameter int CNT_W     = 8,
  parameter int TIME_W    = 16,
  parameter int NB_IN_W   = 6,
  localparam int NBW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NB_IN_W-1:0]  nbits_i,
  input  logic [MAX_BITS-1:0] ks_i,
  input  logic                tick_i,
  input  logic [TIME_W-1:0]   time_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic                win_clr_o,
  output logic                fin_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic [NBW-1:0]      nbits_o
);
  localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [WW-1:0]     WIN_LAST = WW'(WIN_TICKS - 1);
  localparam logic [TIME_W-1:0] DLY_LAST = TIME_W'(START_DLY - 1);

  rx_state_e           state_q;
  logic [WW-1:0]       wcnt_q;
  logic [NBW-1:0]      bidx_q, nb_q, nb_clamp;
  logic [MAX_BITS-1:0] acc_q, acc_nx, ks_mask;
  logic                done_q;
  logic [MAX_BITS-1:0] data_q;
  logic [NBW-1:0]      nbo_q;
  logic                dly_end, win_end, bit_one, last_bit, fin;

  always_comb begin
    nb_clamp = (int'(nbits_i) > MAX_BITS) ? NBW'(MAX_BITS) : NBW'(nbits_i);
    for (int i = 0; i < MAX_BITS; i++) ks_mask[i] = (i < int'(nb_clamp));
  end

  assign dly_end   = (state_q == RX_WAIT) && tick_i && (time_i == DLY_LAST);
  assign win_end   = (state_q == RX_RECV) && tick_i && (wcnt_q == WIN_LAST);
  assign bit_one   = (int'(cnt_i) > CNT_LO) && (int'(cnt_i) < CNT_HI);
  assign last_bit  = (bidx_q == nb_q - 1'b1);
  assign acc_nx    = acc_q ^ (MAX_BITS'(bit_one) << bidx_q);
  assign fin       = !start_i && ((dly_end && nb_q == '0) || (win_end && last_bit));
  assign win_clr_o = dly_end || win_end;
  assign fin_o     = fin;
  assign busy_o    = (state_q != RX_IDLE);
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign nbits_o   = nbo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      wcnt_q  <= '0;
      bidx_q  <= '0;
      nb_q    <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
      nbo_q   <= '0;
    end else if (start_i) begin
      state_q <= RX_WAIT;
      wcnt_q  <= '0;
      bidx_q  <= '0;
      nb_q    <= nb_clamp;
      acc_q   <= ks_i & ks_mask;
      done_q  <= 1'b0;
      data_q  <= '0;
      nbo_q   <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        data_q <= win_end ? acc_nx : acc_q;
        nbo_q  <= nb_q;
      end
      unique case (state_q)
        RX_WAIT: if (dly_end) begin
          state_q <= (nb_q == '0) ? RX_IDLE : RX_RECV;
          wcnt_q  <= '0;
          bidx_q  <= '0;
        end
        RX_RECV: begin
          if (tick_i) wcnt_q <= win_end ? '0 : wcnt_q + 1'b1;
          if (win_end) begin
            acc_q  <= acc_nx;
            bidx_q <= bidx_q + 1'b1;
            if (last_bit) state_q <= RX_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_data_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (done_o || ($stable(data_o) && $stable(nbits_o))));
  p_nbits_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(nbits_o) <= MAX_BITS);
  // R10: the frame never ends before its last window closes
  p_full_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_RECV && !start_i && !(win_end && last_bit)) |=> busy_o);
endmodule

// File: rtl/sc_edge_rx.sv
module sc_edge_rx #(
  parameter int TICK_DIV  = 32,
  parameter int START_DLY = 490,
  parameter int WIN_TICKS = 150,
  parameter int CNT_LO    = 20,
  parameter int CNT_HI    = 60,
  parameter int CNT_W     = 8,
  parameter int MAX_BITS  = 32,
  parameter int TIME_W    = 16,
  parameter int NB_IN_W   = 6,
  localparam int NBW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NB_IN_W-1:0]  nbits_i,
  input  logic [MAX_BITS-1:0] ks_i,
  input  logic                sc_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic [NBW-1:0]      nbits_o,
  output logic [TIME_W-1:0]   time_o
);
  logic             tick, win_clr, fin;
  logic [CNT_W-1:0] cnt;

  sc_rx_timebase #(.TICK_DIV(TICK_DIV), .TIME_W(TIME_W)) u_tb (
    .clk_i, .rst_ni, .clr_i(start_i | fin), .tick_o(tick), .time_o(time_o));

  sc_rx_edge_cnt #(.CNT_W(CNT_W)) u_ec (
    .clk_i, .rst_ni, .sc_i, .clr_i(win_clr), .cnt_o(cnt));

  sc_rx_ctrl #(
    .START_DLY(START_DLY), .WIN_TICKS(WIN_TICKS), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI),
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .TIME_W(TIME_W), .NB_IN_W(NB_IN_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .nbits_i, .ks_i, .tick_i(tick), .time_i(time_o),
    .cnt_i(cnt), .win_clr_o(win_clr), .fin_o(fin), .busy_o, .done_o, .data_o, .nbits_o);

  p_time_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> time_o == '0);
endmodule

// File: tb/sc_edge_rx_tb.sv
module sc_edge_rx_tb;
  localparam int DIV = 2, SD = 10, WIN = 12, LO = 3, HI = 8, CW = 4;
  localparam int MAXB = 32, TW = 16, NIW = 6, WD = WIN * DIV;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sc = 1'b0;
  logic [NIW-1:0]  nbits = '0;
  logic [MAXB-1:0] ks = '0;
  logic busy, done;
  logic [MAXB-1:0] data;
  logic [5:0]      nbo;
  logic [TW-1:0]   tim;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int cnts[0:39];

  always #5 clk = ~clk;

  sc_edge_rx #(.TICK_DIV(DIV), .START_DLY(SD), .WIN_TICKS(WIN), .CNT_LO(LO), .CNT_HI(HI),
    .CNT_W(CW), .MAX_BITS(MAXB), .TIME_W(TW), .NB_IN_W(NIW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nbits_i(nbits), .ks_i(ks), .sc_i(sc),
    .busy_o(busy), .done_o(done), .data_o(data), .nbits_o(nbo), .time_o(tim));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(int n);
    int e = (n > 15) ? 15 : n;
    return (e > LO) && (e < HI);
  endfunction

  task automatic run_frame(input int nreq, input logic [31:0] kw);
    int nbc = (nreq > MAXB) ? MAXB : nreq;
    logic [31:0] exp = '0;
    for (int i = 0; i < nbc; i++) exp[i] = exp_bit(cnts[i]) ^ kw[i];
    @(negedge clk); start = 1'b1; nbits = NIW'(nreq); ks = kw;
    @(negedge clk); start = 1'b0; ks = $urandom;
    chk(busy == 1'b1, "R2 busy", 32'(busy), 1);
    chk(data == '0 && nbo == '0, "R2 clear", data, 0);
    chk(tim == '0, "R2 time", 32'(tim), 0);
    repeat (SD * DIV - 1) @(negedge clk);
    chk(tim == TW'(SD - 1), "R3 lead-in", 32'(tim), SD - 1);
    @(negedge clk);
    for (int b = 0; b < nbc; b++) begin
      for (int j = 0; j < WD; j++) begin
        @(negedge clk);
        if (j >= 2 && j < 2 + cnts[b]) sc = ~sc;
        if (b == nbc - 1 && j == WD - 2) chk(done == 1'b0, "R10 R4 early done", 32'(done), 0);
      end
    end
    chk(done == 1'b1, "R4 R10 done time", 32'(done), 1);
    chk(data == exp, "R5 R6 R8 R9 data", data, exp);
    chk(int'(nbo) == nbc, "R7 nbits", 32'(nbo), nbc);
    chk(tim == '0, "R12 time cleared", 32'(tim), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 pulse", 32'(done), 0);
    @(negedge clk);
    chk(tim == TW'(1), "R12 time counts", 32'(tim), 1);
    chk(data == exp && int'(nbo) == nbc && !busy, "R11 hold", data, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !done && data == '0 && nbo == '0 && tim == '0, "R1 reset", data, 0);
    rst_n = 1'b1;
    // R5 band edges: LO, LO+1, HI-1, HI -> 0,1,1,0
    cnts[0] = LO; cnts[1] = LO + 1; cnts[2] = HI - 1; cnts[3] = HI;
    run_frame(4, 32'h0);
    // R6 only window 0 decodes as 1
    for (int i = 0; i < 8; i++) cnts[i] = (i == 0) ? 5 : 0;
    run_frame(8, 32'h0);
    // R9 20 edges saturate at 15 -> 0; window 1 gives 1
    cnts[0] = 20; cnts[1] = 5;
    run_frame(2, 32'h0);
    // R10 all-zero frame, data equals masked keystream (R8)
    for (int i = 0; i < 16; i++) cnts[i] = 0;
    run_frame(16, 32'hA5C3_5A3C);
    // R7 request of 40 clamps to 32
    for (int i = 0; i < 40; i++) cnts[i] = (i % 3 == 0) ? 6 : 1;
    run_frame(40, 32'h1234_5678);
    // random frames
    for (int f = 0; f < 8; f++) begin
      int n = $urandom_range(1, MAXB);
      for (int i = 0; i < 40; i++) cnts[i] = $urandom_range(0, 20);
      run_frame(n, $urandom);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule